// File: doc/BRIEF.md
# Serial Programming Target Controller

This block is the device side of a byte-oriented serial programming link. A host drives a serial clock and a data line into the device and reads a response line back; every instruction is a frame of exactly four bytes. The controller shifts the frames in, decodes them, and acts on them. The actions are: unlocking programming access, filling a word-wide page buffer one byte at a time, committing that buffer to a behavioural flash array, reading flash bytes back, and reporting whether a page commit is still in progress.

Programming access starts locked after every reset. It opens only when an unlock frame arrives with the key 0x53 as its second byte. The device echoes that key while the third byte is shifting, so the host can confirm that the link is aligned. The host loads the low byte of each buffer word before its high byte. It then commits the buffer with a separate page-address frame. The device stays busy for a fixed number of system clocks after each commit.

Top module: `spt_target`

## Requirements
- R1: The line `mosi` is sampled on each rising edge of `sck`, most significant bit first. Every frame is exactly four bytes: opcode, address high, address low, data/response. The 16-bit address splits into a page number in bits 12..6 and a word index in bits 5..0.
- R2: `miso` changes only in the system clock cycle after a falling edge of `sck`, and it is 0 after reset. The response byte for frame byte k+1 is shifted out MSB first, starting at the falling edge that follows the last bit of byte k.
- R3: If the opcode is 0xAC and the second byte is 0x53, the third response byte is 0x53. In every other case the third response byte is 0x00. A frame with a wrong key is still consumed whole.
- R4: Until a frame 0xAC 0x53 xx xx has completed since the last reset, every other instruction has no effect, and its fourth response byte is 0x00.
- R5: Opcode 0x40 (load-low) writes the data byte into the low half of the buffer word given by the word index.
- R6: Opcode 0x48 (load-high) writes the high half of a buffer word only if that word's low half has been loaded since the last commit or reset. Otherwise it is ignored.
- R7: Opcode 0x4C (write-page) copies the entire buffer into flash page (page number mod 2^PAGE_AW). It then returns every buffer word to 0xFFFF and forgets which low halves were loaded.
- R8: After a commit the block is busy for BUSY_CYCLES system clocks. Opcode 0xF0 (poll) returns 0x01 in the fourth response byte while busy, and 0x00 otherwise.
- R9: While busy, load and write-page instructions are ignored.
- R10: Opcode 0x20 (read-low) and opcode 0x28 (read-high) return the low byte or the high byte of the addressed flash word in the fourth response byte. Flash contents survive `rst`.
- R11: Asserting `rst` in the middle of a frame clears the bit and byte position. The next byte sent is then decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; `sck` and `mosi` are sampled with it |
| rst | input | 1 | Active-high reset; relocks access and clears frame position |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial response data to the host |

## Verification
The busy timer and the instruction decoder meet in two ways. A frame can finish while a commit window is still open, and a poll can sample the status just after that window has closed. The bench issues a load frame whose last bit lands inside the window, then a poll whose status is latched after the window ends. It judges the result by the poll reading zero and by a later readback showing that the load never reached flash. The second meeting point is a reset raised between two bytes of a frame. That reset must beat the shifter, and the bench judges this by the next unlock frame echoing its key in the correct byte slot.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam logic [7:0] OP_ENABLE  = 8'hAC;
  localparam logic [7:0] ENABLE_KEY = 8'h53;
  localparam logic [7:0] OP_LD_LO   = 8'h40;
  localparam logic [7:0] OP_LD_HI   = 8'h48;
  localparam logic [7:0] OP_WR_PAGE = 8'h4C;
  localparam logic [7:0] OP_RD_LO   = 8'h20;
  localparam logic [7:0] OP_RD_HI   = 8'h28;
  localparam logic [7:0] OP_POLL    = 8'hF0;

  localparam int WORD_AW = 6;
  localparam int PAGE_FW = 7;
  localparam int WORDS   = 1 << WORD_AW;
  localparam int PAGE_W  = WORDS * 16;

  function automatic logic [WORD_AW-1:0] word_of(input logic [15:0] addr);
    return addr[WORD_AW-1:0];
  endfunction

  function automatic logic [PAGE_FW-1:0] page_of(input logic [15:0] addr);
    return addr[WORD_AW+PAGE_FW-1:WORD_AW];
  endfunction
endpackage

// File: rtl/spt_shifter.sv
module spt_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       mosi,
  input  logic [7:0] resp_byte,
  output logic       miso,
  output logic       byte_done,
  output logic [1:0] byte_idx,
  output logic [7:0] rx_byte
);
  logic       sck_q;
  logic       sck_rise;
  logic       sck_fall;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;

  assign sck_rise  = sck & ~sck_q;
  assign sck_fall  = ~sck & sck_q;
  assign rx_byte   = {rx_sh, mosi};
  assign byte_done = sck_rise && (bit_cnt == 3'd7);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sck_q    <= 1'b1;
      bit_cnt  <= '0;
      byte_idx <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      miso     <= 1'b0;
    end else begin
      sck_q <= sck;
      if (sck_rise) begin
        rx_sh   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (byte_done) begin
          byte_idx <= byte_idx + 2'd1;
          tx_sh    <= resp_byte;
        end
      end
      if (sck_fall) begin
        miso  <= tx_sh[7];
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  // R2: the response line moves only after a falling serial clock edge
  p_miso_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (miso != $past(miso)) |-> $past(sck_fall));
endmodule

// File: rtl/spt_decoder.sv
module spt_decoder
  import spt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_done,
  input  logic [1:0]  byte_idx,
  input  logic [7:0]  rx_byte,
  input  logic        busy,
  input  logic [15:0] rd_word,
  output logic [15:0] rd_addr,
  output logic [7:0]  resp_byte,
  output logic        ld_lo,
  output logic        ld_hi,
  output logic        wr_pg,
  output logic [15:0] cmd_addr,
  output logic [7:0]  cmd_data
);
  logic [7:0] op_q;
  logic [7:0] ah_q;
  logic [7:0] al_q;
  logic       enabled;
  logic       frame_done;
  logic       exec_ok;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      op_q    <= '0;
      ah_q    <= '0;
      al_q    <= '0;
      enabled <= 1'b0;
    end else if (byte_done) begin
      unique case (byte_idx)
        2'd0: op_q <= rx_byte;
        2'd1: ah_q <= rx_byte;
        2'd2: al_q <= rx_byte;
        2'd3: if (op_q == OP_ENABLE && ah_q == ENABLE_KEY) enabled <= 1'b1;
      endcase
    end
  end

  assign frame_done = byte_done && (byte_idx == 2'd3);
  assign exec_ok    = frame_done && enabled && !busy;
  assign ld_lo      = exec_ok && (op_q == OP_LD_LO);
  assign ld_hi      = exec_ok && (op_q == OP_LD_HI);
  assign wr_pg      = exec_ok && (op_q == OP_WR_PAGE);
  assign cmd_addr   = {ah_q, al_q};
  assign cmd_data   = rx_byte;
  assign rd_addr    = {ah_q, rx_byte};

  always_comb begin
    resp_byte = 8'h00;
    if (byte_idx == 2'd1 && op_q == OP_ENABLE && rx_byte == ENABLE_KEY) begin
      resp_byte = ENABLE_KEY;
    end else if (byte_idx == 2'd2 && enabled) begin
      case (op_q)
        OP_RD_LO: resp_byte = rd_word[7:0];
        OP_RD_HI: resp_byte = rd_word[15:8];
        OP_POLL:  resp_byte = {7'd0, busy};
        default:  resp_byte = 8'h00;
      endcase
    end
  end

  // R4: access opens only at the end of a frame
  p_unlock_at_frame_end_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(enabled) |-> $past(frame_done));
  // R3: a nonzero third-byte response is only ever the echoed key
  p_echo_key_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_done && byte_idx == 2'd1 && resp_byte != 8'h00) |-> (rx_byte == ENABLE_KEY));
endmodule

// File: rtl/spt_pagebuf.sv
module spt_pagebuf
  import spt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              clear,
  input  logic [15:0]       cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic [PAGE_W-1:0] page_img
);
  logic [WORD_AW-1:0] sel;
  logic               unused_addr_bits;

  assign sel              = word_of(cmd_addr);
  assign unused_addr_bits = ^cmd_addr;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [15:0] word_q;
    logic        lo_ok;
    logic        hit;

    assign hit = (sel == WORD_AW'(w));

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        word_q <= 16'hFFFF;
        lo_ok  <= 1'b0;
      end else if (clear) begin
        word_q <= 16'hFFFF;
        lo_ok  <= 1'b0;
      end else if (ld_lo && hit) begin
        word_q[7:0] <= cmd_data;
        lo_ok       <= 1'b1;
      end else if (ld_hi && hit && lo_ok) begin
        word_q[15:8] <= cmd_data;
      end
    end

    assign page_img[w*16 +: 16] = word_q;

    // R6: a high byte without its low byte leaves the word untouched
    p_hi_needs_lo_r6: assert property (@(posedge clk) disable iff (rst)
      (ld_hi && hit && !lo_ok && !clear) |=> $stable(word_q));
  end
endmodule

// File: rtl/spt_flash.sv
module spt_flash
  import spt_pkg::*;
#(
  parameter int PAGE_AW     = 4,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [15:0]       cmd_addr,
  input  logic [PAGE_W-1:0] page_img,
  input  logic [15:0]       rd_addr,
  output logic [15:0]       rd_word,
  output logic              busy
);
  localparam int PAGES = 1 << PAGE_AW;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [PAGE_W-1:0]  mem_q [PAGES];
  logic [PAGE_FW-1:0] wr_pg;
  logic [PAGE_FW-1:0] rd_pg;
  logic [WORD_AW-1:0] rd_w;
  logic [CNT_W-1:0]   busy_cnt;
  logic               unused_addr_bits;

  assign wr_pg            = page_of(cmd_addr);
  assign rd_pg            = page_of(rd_addr);
  assign rd_w             = word_of(rd_addr);
  assign unused_addr_bits = ^{cmd_addr, rd_addr, wr_pg, rd_pg};

  always_ff @(posedge clk) begin
    if (commit) mem_q[wr_pg[PAGE_AW-1:0]] <= page_img;
  end

  assign rd_word = mem_q[rd_pg[PAGE_AW-1:0]][{rd_w, 4'b0000} +: 16];

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                busy_cnt <= '0;
    else if (commit)        busy_cnt <= CNT_W'(BUSY_CYCLES);
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1'b1;
  end

  assign busy = (busy_cnt != '0);

  // R8: a commit opens the busy window on the next cycle
  p_busy_after_commit_r8: assert property (@(posedge clk) disable iff (rst)
    commit |=> busy);
endmodule

// File: rtl/spt_target.sv
module spt_target
  import spt_pkg::*;
#(
  parameter int PAGE_AW     = 4,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  logic              byte_done;
  logic [1:0]        byte_idx;
  logic [7:0]        rx_byte;
  logic [7:0]        resp_byte;
  logic              busy;
  logic [15:0]       rd_addr;
  logic [15:0]       rd_word;
  logic              ld_lo;
  logic              ld_hi;
  logic              wr_pg;
  logic [15:0]       cmd_addr;
  logic [7:0]        cmd_data;
  logic [PAGE_W-1:0] page_img;

  spt_shifter u_shift (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .resp_byte(resp_byte),
    .miso(miso), .byte_done(byte_done), .byte_idx(byte_idx), .rx_byte(rx_byte)
  );

  spt_decoder u_dec (
    .clk(clk), .rst(rst), .byte_done(byte_done), .byte_idx(byte_idx),
    .rx_byte(rx_byte), .busy(busy), .rd_word(rd_word), .rd_addr(rd_addr),
    .resp_byte(resp_byte), .ld_lo(ld_lo), .ld_hi(ld_hi), .wr_pg(wr_pg),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  spt_pagebuf u_buf (
    .clk(clk), .rst(rst), .ld_lo(ld_lo), .ld_hi(ld_hi), .clear(wr_pg),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .page_img(page_img)
  );

  spt_flash #(.PAGE_AW(PAGE_AW), .BUSY_CYCLES(BUSY_CYCLES)) u_flash (
    .clk(clk), .rst(rst), .commit(wr_pg), .cmd_addr(cmd_addr),
    .page_img(page_img), .rd_addr(rd_addr), .rd_word(rd_word), .busy(busy)
  );

  // R9: no buffer or flash update is issued inside the busy window
  p_quiet_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(ld_lo || ld_hi || wr_pg));
endmodule

// File: tb/spt_target_tb.sv
module spt_target_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  always #5 clk = ~clk;

  spt_target #(.PAGE_AW(4), .BUSY_CYCLES(400)) u_dut (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .miso(miso)
  );

  typedef struct {
    int         pos;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   sent = 0;
  int   vectors = 0;
  int   miscompares = 0;
  int   r2_bad = 0;
  bit   finished = 0;

  // scoreboard monitor: assemble response bytes as the host would see them
  initial begin
    logic [7:0] sh;
    int bits;
    int got;
    sh = '0; bits = 0; got = 0;
    forever begin
      @(posedge sck);
      sh = {sh[6:0], miso};
      bits++;
      if (bits == 8) begin
        bits = 0;
        if (exp_q.size() > 0 && exp_q[0].pos == got) begin
          vectors++;
          if (sh !== exp_q[0].val) begin
            miscompares++;
            $display("FAIL %s: got %02h expected %02h", exp_q[0].tag, sh, exp_q[0].val);
          end
          void'(exp_q.pop_front());
        end
        got++;
      end
    end
  end

  // R2: the response line must never move while the serial clock is high
  always @(miso) if (sck === 1'b1) r2_bad++;

  task automatic sbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      #40 sck = 1'b1;
      #40 sck = 1'b0;
    end
    sent++;
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [7:0] b3, input int chk, input logic [7:0] ev,
                       input string tag);
    exp_t e;
    if (chk >= 0) begin
      e.pos = sent + chk; e.val = ev; e.tag = tag;
      exp_q.push_back(e);
    end
    @(negedge clk);
    sbyte(b0); sbyte(b1); sbyte(b2); sbyte(b3);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    vectors++;
    if (miso !== 1'b0) begin
      miscompares++;
      $display("FAIL R2 reset: got %b expected 0", miso);
    end
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // locked: reads, polls and loads do nothing
    frame(8'h20, 8'h00, 8'h40, 8'h00, 3, 8'h00, "R4 read while locked");
    frame(8'hF0, 8'h00, 8'h00, 8'h00, 3, 8'h00, "R4 poll while locked");
    frame(8'h40, 8'h00, 8'h05, 8'hA5, -1, 8'h00, "");
    frame(8'hAC, 8'h52, 8'h00, 8'h00, 2, 8'h00, "R3 wrong key no echo");
    frame(8'h20, 8'h00, 8'h40, 8'h00, 3, 8'h00, "R4 still locked after bad key");
    frame(8'hAC, 8'h53, 8'h00, 8'h00, 2, 8'h53, "R3 R1 key echoed");

    // fill page 1 buffer
    frame(8'h40, 8'h00, 8'h00, 8'h11, -1, 8'h00, "");
    frame(8'h48, 8'h00, 8'h00, 8'h22, -1, 8'h00, "");
    frame(8'h40, 8'h00, 8'h3F, 8'h33, -1, 8'h00, "");
    frame(8'h48, 8'h00, 8'h3F, 8'h44, -1, 8'h00, "");
    frame(8'h48, 8'h00, 8'h07, 8'h55, -1, 8'h00, "");
    frame(8'h40, 8'h00, 8'h09, 8'h66, -1, 8'h00, "");
    frame(8'h4C, 8'h00, 8'h40, 8'h00, -1, 8'h00, "");
    // load lands inside the busy window; poll samples after it closes
    frame(8'h40, 8'h00, 8'h05, 8'h77, -1, 8'h00, "");
    frame(8'hF0, 8'h00, 8'h00, 8'h00, 3, 8'h00, "R8 idle after window");

    frame(8'h20, 8'h00, 8'h40, 8'h00, 3, 8'h11, "R5 R10 word0 low");
    frame(8'h28, 8'h00, 8'h40, 8'h00, 3, 8'h22, "R10 word0 high");
    frame(8'h20, 8'h00, 8'h7F, 8'h00, 3, 8'h33, "R5 word63 low");
    frame(8'h28, 8'h00, 8'h7F, 8'h00, 3, 8'h44, "R10 word63 high");
    frame(8'h28, 8'h00, 8'h47, 8'h00, 3, 8'hFF, "R6 high without low ignored");
    frame(8'h20, 8'h00, 8'h47, 8'h00, 3, 8'hFF, "R7 unloaded word erased");
    frame(8'h20, 8'h00, 8'h49, 8'h00, 3, 8'h66, "R5 word9 low");
    frame(8'h28, 8'h00, 8'h49, 8'h00, 3, 8'hFF, "R6 word9 high untouched");
    frame(8'h20, 8'h00, 8'h45, 8'h00, 3, 8'hFF, "R4 locked load had no effect");
    frame(8'h20, 8'h04, 8'h40, 8'h00, 3, 8'h11, "R7 page 17 aliases page 1");

    // commit page 2 from an erased buffer, poll at once
    frame(8'h4C, 8'h00, 8'h80, 8'h00, -1, 8'h00, "");
    frame(8'hF0, 8'h00, 8'h00, 8'h00, 3, 8'h01, "R8 busy after commit");
    repeat (500) @(negedge clk);
    frame(8'h20, 8'h00, 8'h85, 8'h00, 3, 8'hFF, "R9 busy load ignored, R7 buffer cleared");

    // reset between bytes of a frame
    @(negedge clk);
    sbyte(8'h20); sbyte(8'h00);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    frame(8'h20, 8'h00, 8'h40, 8'h00, 3, 8'h00, "R11 R4 relocked after reset");
    frame(8'hAC, 8'h53, 8'h00, 8'h00, 2, 8'h53, "R11 frame aligned after reset");
    frame(8'h20, 8'h00, 8'h40, 8'h00, 3, 8'h11, "R10 flash kept over reset");

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    vectors++;
    if (r2_bad != 0) begin
      miscompares++;
      $display("FAIL R2 miso moved with sck high: got %0d expected 0", r2_bad);
    end
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule